// File: doc/BRIEF.md
# Prioritised Peripheral Request Router

This block connects up to 64 peripheral DMA request lines to up to 32 transfer channels and decides which channel may use a shared bus next. Each request line has its own routing register. That register holds an enable flag and the number of the channel that the line drives. A channel takes part in arbitration when software has set its run input and at least one enabled request line routed to it is asserted. Several lines may route to the same channel, and their requests are ORed.

Competing channels are sorted into four fixed priority levels. The level is taken from bits 3:2 of the channel index, so channels 0-3 and 16-19 form level 0 (the highest), 4-7 and 20-23 form level 1, 8-11 and 24-27 form level 2, and 12-15 and 28-31 form level 3. The highest non-empty level wins. Inside a level, a rotating pointer per level chooses among the competitors. The grant is registered, is one-hot, and holds until the owning channel pulses `burst_done`. The same register port also returns a word with one bit per channel that mirrors the channel interrupt inputs.

The grant controller has two states. `ST_IDLE` means no grant is out. `ST_HOLD` means one channel owns the bus. The transition ARB_WIN goes from `ST_IDLE` to `ST_HOLD` when any channel competes. The transition BURST_END goes from `ST_HOLD` back to `ST_IDLE` when `burst_done` is seen. No other transitions exist.

Top module: `prr_router`

## Requirements
- R1: The routing register of request line r is at byte address 0x100 + 4*r. A write stores bit 7 (enable) and bits 4:0 (channel number). A read returns those bits in the same positions, with every other bit read as 0.
- R2: A request line whose routing register has bit 7 clear has no effect on the grant.
- R3: A channel competes only when its `ch_run` bit is 1 and an enabled request line routed to it is asserted. From `ST_IDLE` with a competitor present, the grant appears on the next clock edge.
- R4: The level of channel c is (c mod 16) div 4, and level 0 is the highest. A competitor in a higher level always wins over one in a lower level.
- R5: Within one level, the search starts at the index just after the channel last granted in that level and wraps around, so the channels with requests are served in rotation. After reset, each search starts at index 0.
- R6: While `grant_valid` is 1, `grant` has exactly one bit set, and it stays unchanged until `burst_done` is sampled high. When `grant_valid` is 0, `grant` is all zero.
- R7: After `burst_done` is sampled in `ST_HOLD`, `grant_valid` is 0 for one cycle, and arbitration happens again on the following edge.
- R8: A read of byte address 0x0F0 returns `ch_irq`, with bit n equal to channel n's interrupt input.
- R9: After reset, `grant_valid` is 0 and every routing register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| periph_req | input | 64 | Peripheral request lines |
| ch_run | input | 32 | Per-channel run enables |
| ch_irq | input | 32 | Per-channel interrupt pending inputs |
| burst_done | input | 1 | The granted channel has finished its burst |
| grant | output | 32 | One-hot channel grant |
| grant_valid | output | 1 | A grant is out |

## Verification
The rotation pointer inside one level is the hardest thing to observe from the ports. It only shows when several channels of the same level keep competing over several bursts, and it depends on which channel of that level last won, possibly many bursts earlier. The stimulus first lets channel 16 win in level 0. It then keeps channels 0, 1 and 17 requesting through back-to-back bursts, so the expected order is 17, 0, 1 and then 17 again. Priority between levels is checked by raising requests during a held grant, so that all levels compete at the same moment when the burst ends.

// File: rtl/prr_pkg.sv
package prr_pkg;
    localparam int unsigned NUM_LVL = 4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } gstate_e;

    // priority level of a channel: bits 3:2 of its index
    function automatic int unsigned chan_level(input int unsigned idx);
        return (idx >> 2) & (NUM_LVL - 1);
    endfunction
endpackage

// File: rtl/prr_req_map.sv
module prr_req_map #(
    parameter int NUM_REQ = 64,
    parameter int NUM_CH  = 32,
    parameter int AW      = 12,
    parameter int DW      = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    input  logic [NUM_REQ-1:0]          periph_req,
    output logic [DW-1:0]               map_rdata,
    output logic [NUM_CH-1:0]           chan_req
);
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int MAP_BASE = 'h100;
    localparam int VLD_BIT  = 7;

    logic [NUM_REQ-1:0] map_vld;
    logic [CH_W-1:0]    map_ch [NUM_REQ];

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_map
        localparam logic [AW-1:0] SLOT = AW'(MAP_BASE + 4 * r);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                map_vld[r] <= 1'b0;
                map_ch[r]  <= '0;
            end else if (wr_en && addr == SLOT) begin
                map_vld[r] <= wdata[VLD_BIT];
                map_ch[r]  <= wdata[CH_W-1:0];
            end
        end
    end

    always_comb begin
        map_rdata = '0;
        for (int r = 0; r < NUM_REQ; r++) begin
            if (addr == AW'(MAP_BASE + 4 * r)) begin
                map_rdata[VLD_BIT]    = map_vld[r];
                map_rdata[CH_W-1:0]   = map_ch[r];
            end
        end
    end

    always_comb begin
        chan_req = '0;
        for (int r = 0; r < NUM_REQ; r++) begin
            if (map_vld[r] && periph_req[r])
                chan_req[map_ch[r]] = 1'b1;
        end
    end

    // a disabled slot must never raise a channel on its own
    AST_SOLE_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_req == NUM_REQ'(1) && !map_vld[0]) |-> chan_req == '0) // R2
        else $error("disabled routing slot raised a channel");
endmodule

// File: rtl/prr_level_arb.sv
module prr_level_arb #(
    parameter int NUM_CH = 32,
    parameter int LVL    = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CH-1:0]           active,
    input  logic                        take,
    output logic                        any,
    output logic [$clog2(NUM_CH)-1:0]   win_idx
);
    import prr_pkg::*;
    localparam int CH_W = $clog2(NUM_CH);

    logic [CH_W-1:0] last_q;

    always_comb begin
        any     = 1'b0;
        win_idx = '0;
        for (int i = 1; i <= NUM_CH; i++) begin
            int unsigned idx;
            idx = (int'(last_q) + i) % NUM_CH;
            if (!any && active[idx] && chan_level(idx) == LVL) begin
                any     = 1'b1;
                win_idx = CH_W'(idx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last_q <= CH_W'(NUM_CH - 1);
        else if (take)
            last_q <= win_idx;
    end

    AST_WIN_REQUESTING: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> active[win_idx]) // R5
        else $error("level winner is not competing");
    AST_PTR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> last_q == $past(win_idx)) // R5
        else $error("rotation pointer did not follow winner");
endmodule

// File: rtl/prr_grant_fsm.sv
module prr_grant_fsm #(
    parameter int NUM_CH = 32
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic [prr_pkg::NUM_LVL-1:0]                       lvl_any,
    input  logic [prr_pkg::NUM_LVL-1:0][$clog2(NUM_CH)-1:0]   lvl_win,
    input  logic                                              burst_done,
    output logic [prr_pkg::NUM_LVL-1:0]                       take,
    output logic [NUM_CH-1:0]                                 grant,
    output logic                                              grant_valid
);
    import prr_pkg::*;
    localparam int CH_W = $clog2(NUM_CH);

    gstate_e         state_q, state_d;
    logic [CH_W-1:0] pick_idx;
    logic [NUM_CH-1:0] grant_q;

    // next state and level selection
    always_comb begin
        state_d  = state_q;
        take     = '0;
        pick_idx = '0;
        unique case (state_q)
            ST_IDLE: begin
                for (int l = NUM_LVL - 1; l >= 0; l--) begin
                    if (lvl_any[l]) begin
                        take     = '0;
                        take[l]  = 1'b1;
                        pick_idx = lvl_win[l];
                    end
                end
                if (|lvl_any) state_d = ST_HOLD;       // ARB_WIN
            end
            ST_HOLD: begin
                if (burst_done) state_d = ST_IDLE;     // BURST_END
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grant_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_HOLD)
                grant_q <= NUM_CH'(1) << pick_idx;
            else if (state_d == ST_IDLE)
                grant_q <= '0;
        end
    end

    assign grant       = grant_q;
    assign grant_valid = (state_q == ST_HOLD);

    AST_ONE_LEVEL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take)) // R4
        else $error("more than one level granted");
    AST_IDLE_TO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && |lvl_any) |=> grant_valid) // R3
        else $error("competitor present but no grant");
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $countones(grant) == 1) // R6
        else $error("grant not one-hot");
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> grant == '0) // R6
        else $error("grant bits set without valid");
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !burst_done) |=> (grant_valid && $stable(grant))) // R6
        else $error("grant changed before burst end");
    AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && burst_done) |=> !grant_valid) // R7
        else $error("no idle cycle after burst end");
endmodule

// File: rtl/prr_router.sv
module prr_router #(
    parameter int NUM_REQ = 64,
    parameter int NUM_CH  = 32,
    parameter int AW      = 12,
    parameter int DW      = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [AW-1:0]       reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    input  logic [NUM_REQ-1:0]  periph_req,
    input  logic [NUM_CH-1:0]   ch_run,
    input  logic [NUM_CH-1:0]   ch_irq,
    input  logic                burst_done,
    output logic [NUM_CH-1:0]   grant,
    output logic                grant_valid
);
    import prr_pkg::*;
    localparam int CH_W = $clog2(NUM_CH);
    localparam logic [AW-1:0] IRQ_ADDR = AW'('h0F0);

    logic [DW-1:0]                    map_rdata;
    logic [NUM_CH-1:0]                chan_req;
    logic [NUM_CH-1:0]                active;
    logic [NUM_LVL-1:0]               lvl_any;
    logic [NUM_LVL-1:0][CH_W-1:0]     lvl_win;
    logic [NUM_LVL-1:0]               take;

    prr_req_map #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_map (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .periph_req(periph_req),
        .map_rdata(map_rdata), .chan_req(chan_req)
    );

    assign active = chan_req & ch_run;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        prr_level_arb #(.NUM_CH(NUM_CH), .LVL(l)) u_arb (
            .clk(clk), .rst_n(rst_n), .active(active), .take(take[l]),
            .any(lvl_any[l]), .win_idx(lvl_win[l])
        );
    end

    prr_grant_fsm #(.NUM_CH(NUM_CH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .lvl_any(lvl_any), .lvl_win(lvl_win),
        .burst_done(burst_done), .take(take), .grant(grant),
        .grant_valid(grant_valid)
    );

    always_comb begin
        if (reg_addr == IRQ_ADDR)
            reg_rdata = DW'(ch_irq);
        else
            reg_rdata = map_rdata;
    end

    AST_GRANT_WAS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> |(grant & $past(active))) // R3
        else $error("grant went to a channel that was not competing");
endmodule

// File: tb/sim_prr_router.sv
`timescale 1ns/1ps
module sim_prr_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] periph_req = '0;
    logic [31:0] ch_run = '0;
    logic [31:0] ch_irq = '0;
    logic        burst_done = 1'b0;
    logic [31:0] grant;
    logic        grant_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    prr_router u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
        .ch_run(ch_run), .ch_irq(ch_irq), .burst_done(burst_done),
        .grant(grant), .grant_valid(grant_valid)
    );

    // {request index, written byte, expected readback byte}
    localparam int NVEC = 8;
    localparam logic [21:0] VEC [NVEC] = '{
        {6'd0,  8'h85, 8'h85}, {6'd1,  8'hFF, 8'h9F},
        {6'd63, 8'h1F, 8'h1F}, {6'd32, 8'h60, 8'h00},
        {6'd17, 8'hE3, 8'h83}, {6'd40, 8'h80, 8'h80},
        {6'd5,  8'h3A, 8'h1A}, {6'd62, 8'h9F, 8'h9F}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_map(input int r, input logic [7:0] val);
        reg_addr  = 12'(32'h100 + 4 * r);
        reg_wdata = {24'hABCDEF, val};
        reg_we    = 1'b1;
        tick();
        reg_we    = 1'b0;
    endtask

    task automatic rd_map(input int r, output logic [31:0] val);
        reg_addr = 12'(32'h100 + 4 * r);
        #1;
        val = reg_rdata;
    endtask

    task automatic exp_grant(input string tag, input bit v, input int ch);
        chk({tag, " valid"}, 64'(grant_valid), 64'(v));
        chk({tag, " vector"}, 64'(grant), v ? 64'(32'h1 << ch) : 64'h0);
    endtask

    // end the current burst; check the idle gap; land on the re-arbitration edge
    task automatic end_burst();
        burst_done = 1'b1;
        tick();
        burst_done = 1'b0;
        chk("R7 gap", 64'(grant_valid), 64'h0);
        tick();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R9 reset state
        exp_grant("R9 reset", 1'b0, 0);
        rd_map(9, rv);  chk("R9 map clear", 64'(rv), 64'h0);
        rd_map(63, rv); chk("R9 map clear", 64'(rv), 64'h0);

        // R1 table walk: write all, then read all back
        for (int i = 0; i < NVEC; i++) wr_map(int'(VEC[i][21:16]), VEC[i][15:8]);
        for (int i = 0; i < NVEC; i++) begin
            rd_map(int'(VEC[i][21:16]), rv);
            chk("R1 readback", 64'(rv), 64'(VEC[i][7:0]));
        end
        for (int r = 0; r < 64; r++) wr_map(r, 8'h00);

        // R8 interrupt word
        ch_irq = 32'hA500_0003; reg_addr = 12'h0F0; #1;
        chk("R8 irq word", 64'(reg_rdata), 64'hA500_0003);
        ch_irq = 32'h0000_8000; #1;
        chk("R8 irq word", 64'(reg_rdata), 64'h0000_8000);
        ch_irq = '0;

        // routing for later tests
        wr_map(10, 8'h90); // ch16 level0
        wr_map(11, 8'h84); // ch4  level1
        wr_map(12, 8'h8C); // ch12 level3
        wr_map(13, 8'h88); // ch8  level2

        // R2 disabled slot has no effect
        wr_map(3, 8'h05);
        ch_run = 32'hFFFF_FFDF;
        periph_req[3] = 1'b1;
        ch_run[5] = 1'b1;
        repeat (3) tick();
        exp_grant("R2 disabled slot", 1'b0, 0);

        // R3 run bit gates competition
        ch_run[5] = 1'b0;
        wr_map(3, 8'h85);
        tick();
        exp_grant("R3 not running", 1'b0, 0);
        ch_run[5] = 1'b1;
        tick();
        exp_grant("R3 run set", 1'b1, 5);

        // R6 hold while higher priority arrives
        periph_req[13:10] = 4'hF;
        repeat (3) tick();
        exp_grant("R6 held", 1'b1, 5);

        // R4 level ordering: 16, 4, 8, 12
        periph_req[3] = 1'b0;
        end_burst();
        exp_grant("R4 level0 first", 1'b1, 16);
        periph_req[10] = 1'b0;
        end_burst();
        exp_grant("R4 level1 next", 1'b1, 4);
        periph_req[11] = 1'b0;
        end_burst();
        exp_grant("R4 level2 next", 1'b1, 8);
        periph_req[13] = 1'b0;
        end_burst();
        exp_grant("R4 level3 last", 1'b1, 12);
        periph_req[12] = 1'b0;
        end_burst();
        exp_grant("R3 none left", 1'b0, 0);

        // R5 rotation in level0 after ch16 won: 17, 0, 1, 17
        wr_map(20, 8'h80);
        wr_map(21, 8'h81);
        wr_map(22, 8'h91);
        periph_req[22:20] = 3'b111;
        tick();
        exp_grant("R5 rr after 16", 1'b1, 17);
        end_burst();
        exp_grant("R5 rr wrap", 1'b1, 0);
        end_burst();
        exp_grant("R5 rr next", 1'b1, 1);
        end_burst();
        exp_grant("R5 rr cycle", 1'b1, 17);
        periph_req = '0;
        end_burst();
        exp_grant("R7 idle after drop", 1'b0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule